// File: doc/BRIEF.md
# Pipelined Two-Section Biquad Low-Pass Filter

This block is a fourth-order recursive low-pass filter built as a cascade of two second-order sections. Each section owns one multiply-accumulate datapath and walks it through a fixed six-clock schedule. Five clocks take five products: three feed-forward terms and two feedback terms. The sixth clock rounds and saturates the sum, shifts the delay registers and clears the accumulator. The two sections overlap as a two-stage pipeline. While the first section works on sample n, the second works on the first section's result for sample n-1. The filter therefore takes one sample every six clocks.

Coefficients are fixed at elaboration as signed Q2.14 parameters, so each one can hold a value of magnitude up to 2. The multiplier takes both operands to unsigned magnitudes and forms the product with a shift-and-add array. It then negates the product when exactly one operand is negative. A sample strobe that arrives while the first section is still busy is dropped, and a sticky flag records the drop.

Top module: `biquad_cascade`

## Requirements
- R1: While reset is high, and after it is released, out_valid and overrun are low and out_data is 0. All delay registers restart from zero, so the first outputs after reset match a filter whose past inputs and outputs were all zero.
- R2: A strobe accepted at clock edge E produces out_valid high at edge E+12. That pulse lasts exactly one cycle.
- R3: Each section computes y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2] with Q2.14 coefficients (16384 is 1.0). Section 2 takes section 1's outputs as its input, and out_data is section 2's output.
- R4: The accumulated sum is rounded by adding 8192 (2^13) and then shifting arithmetically right by 14. Exact halves therefore round toward plus infinity, so 1.5 gives 2 and -1.5 gives -1.
- R5: Each section's rounded result is saturated to the 16-bit range −32768 to 32767 before it is stored or passed on.
- R6: The multiplier treats an operand of −32768 as −32767, because its magnitude saturates to 32767.
- R7: Strobes spaced six cycles apart are all accepted. Their outputs appear in order, six cycles apart.
- R8: A strobe that arrives in the five cycles after an accepted one, while section 1 is busy, is ignored. It produces no output and changes no filter state.
- R9: An ignored strobe sets overrun, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new output |
| out_data | output | 16 | Signed filtered output sample |
| overrun | output | 1 | Sticky flag set when a strobe was dropped |

## Verification
A wrong step in the MAC schedule or a swapped delay register leaves the impulse response correct only in its first sample. The error then shows in out_data from the second output onward, 18 clocks after the first strobe. Because the feedback path keeps recirculating state, such an error persists rather than fading, so a twenty-sample impulse and a step expose it. A counter fault in either section shifts out_valid away from the twelfth clock, or breaks its one-cycle width, at the very first sample. A dropped-strobe fault shows either as a low overrun flag two clocks after the stray strobe, or as a corrupted output for the next accepted sample.

// File: rtl/biquad_cascade.sv
module biquad_cascade #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter logic signed [W-1:0] S1_B0 = 16'sd2048,
  parameter logic signed [W-1:0] S1_B1 = 16'sd4096,
  parameter logic signed [W-1:0] S1_B2 = 16'sd2048,
  parameter logic signed [W-1:0] S1_A1 = -16'sd16384,
  parameter logic signed [W-1:0] S1_A2 = 16'sd8192,
  parameter logic signed [W-1:0] S2_B0 = 16'sd1024,
  parameter logic signed [W-1:0] S2_B1 = 16'sd2048,
  parameter logic signed [W-1:0] S2_B2 = 16'sd1024,
  parameter logic signed [W-1:0] S2_A1 = -16'sd19661,
  parameter logic signed [W-1:0] S2_A2 = 16'sd7373
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic signed [W-1:0] out_data,
  output logic                overrun
);
  localparam int AW = 2*W + 4;
  localparam int PW = 2*W - 2;
  localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FRAC-1);
  localparam logic signed [AW-1:0] YMAX = AW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - 1;
  localparam logic signed [W-1:0] CF [2][5] = '{
    '{S1_B0, S1_B1, S1_B2, S1_A1, S1_A2},
    '{S2_B0, S2_B1, S2_B2, S2_A1, S2_A2}};

  function automatic logic [W-2:0] mag(input logic signed [W-1:0] v);
    logic [W-1:0] n;
    n = -v;
    if (!v[W-1]) return v[W-2:0];
    else if (v == {1'b1, {(W-1){1'b0}}}) return {(W-1){1'b1}};
    else return n[W-2:0];
  endfunction

  function automatic logic [PW-1:0] umul(input logic [W-2:0] a, input logic [W-2:0] b);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < W-1; i++)
      if (b[i]) p = p + ({{(W-1){1'b0}}, a} << i);
    return p;
  endfunction

  function automatic logic signed [AW-1:0] smul(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b);
    logic signed [AW-1:0] e;
    e = {{(AW-PW){1'b0}}, umul(mag(a), mag(b))};
    return (a[W-1] ^ b[W-1]) ? -e : e;
  endfunction

  logic [2:0]           cnt  [2];
  logic signed [AW-1:0] acc  [2];
  logic signed [W-1:0]  xin  [2];
  logic signed [W-1:0]  x1   [2];
  logic signed [W-1:0]  x2   [2];
  logic signed [W-1:0]  y1   [2];
  logic signed [W-1:0]  y2   [2];
  logic signed [W-1:0]  yo   [2];
  logic                 done [2];

  logic                 start [2];
  logic signed [W-1:0]  sin   [2];
  logic signed [W-1:0]  cmux  [2];
  logic signed [W-1:0]  dmux  [2];
  logic signed [AW-1:0] prod  [2];
  logic signed [AW-1:0] shv   [2];
  logic signed [W-1:0]  ysat  [2];

  logic busy0, take0;
  assign busy0 = (cnt[0] != 3'd0);
  assign take0 = in_valid & ~busy0;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      start[s] = (s == 0) ? take0 : (done[0] & (cnt[1] == 3'd0));
      sin[s]   = (s == 0) ? in_data : yo[0];
      case (cnt[s])
        3'd1:    begin cmux[s] = CF[s][1]; dmux[s] = x1[s];  end
        3'd2:    begin cmux[s] = CF[s][2]; dmux[s] = x2[s];  end
        3'd3:    begin cmux[s] = CF[s][3]; dmux[s] = y1[s];  end
        3'd4:    begin cmux[s] = CF[s][4]; dmux[s] = y2[s];  end
        default: begin cmux[s] = CF[s][0]; dmux[s] = sin[s]; end
      endcase
      prod[s] = smul(cmux[s], dmux[s]);
      shv[s]  = (acc[s] + HALF) >>> FRAC;
      if (shv[s] > YMAX)      ysat[s] = YMAX[W-1:0];
      else if (shv[s] < YMIN) ysat[s] = YMIN[W-1:0];
      else                    ysat[s] = shv[s][W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        cnt[s] <= '0; acc[s] <= '0; xin[s] <= '0; x1[s] <= '0; x2[s] <= '0;
        y1[s] <= '0; y2[s] <= '0; yo[s] <= '0; done[s] <= 1'b0;
      end
      overrun <= 1'b0;
    end else begin
      if (in_valid && busy0) overrun <= 1'b1;
      for (int s = 0; s < 2; s++) begin
        done[s] <= 1'b0;
        if (cnt[s] == 3'd0) begin
          if (start[s]) begin
            acc[s] <= prod[s];
            xin[s] <= sin[s];
            cnt[s] <= 3'd1;
          end
        end else if (cnt[s] == 3'd5) begin
          x2[s]   <= x1[s];
          x1[s]   <= xin[s];
          y2[s]   <= y1[s];
          y1[s]   <= ysat[s];
          yo[s]   <= ysat[s];
          acc[s]  <= '0;
          done[s] <= 1'b1;
          cnt[s]  <= 3'd0;
        end else begin
          acc[s] <= (cnt[s] >= 3'd3) ? acc[s] - prod[s] : acc[s] + prod[s];
          cnt[s] <= cnt[s] + 3'd1;
        end
      end
    end
  end

  assign out_valid = done[1];
  assign out_data  = yo[1];
endmodule

module biquad_cascade_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic busy0,
  input logic take0,
  input logic out_valid,
  input logic overrun
);
  logic [4:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 5'd31) age <= age + 5'd1;
  end

  assert_out_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 5'd13 && $past(take0, 12)) |-> out_valid);
  assert_no_spurious_out_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 5'd13 && out_valid) |-> $past(take0, 12));
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_drop_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy0) |=> overrun);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_take_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    take0 |=> (busy0 && !take0));
endmodule

bind biquad_cascade biquad_cascade_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy0(busy0), .take0(take0),
  .out_valid(out_valid), .overrun(overrun));

// File: tb/biquad_cascade_bench.sv
`timescale 1ns/1ps
module biquad_cascade_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic ov_m, ov_u, ov_g, ovld_m, ovld_u, ovld_g;
  logic signed [15:0] od_m, od_u, od_g;
  int checks = 0;
  int failures = 0;
  int qm[$], qu[$], qg[$];

  always #2.5 clk = ~clk;

  biquad_cascade u_biquad_cascade (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_data(in_data), .out_valid(ovld_m), .out_data(od_m), .overrun(ov_m));
  biquad_cascade #(.S1_B0(16'sd8192), .S1_B1(16'sd0), .S1_B2(16'sd0), .S1_A1(16'sd0), .S1_A2(16'sd0),
                   .S2_B0(16'sd16384), .S2_B1(16'sd0), .S2_B2(16'sd0), .S2_A1(16'sd0), .S2_A2(16'sd0))
    u_unity (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
             .out_valid(ovld_u), .out_data(od_u), .overrun(ov_u));
  biquad_cascade #(.S1_B0(16'sd32767), .S1_B1(16'sd0), .S1_B2(16'sd0), .S1_A1(16'sd0), .S1_A2(16'sd0),
                   .S2_B0(16'sd16384), .S2_B1(16'sd0), .S2_B2(16'sd0), .S2_A1(16'sd0), .S2_A2(16'sd0))
    u_gain (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
            .out_valid(ovld_g), .out_data(od_g), .overrun(ov_g));

  always @(negedge clk) begin
    if (ovld_m) qm.push_back(int'(od_m));
    if (ovld_u) qu.push_back(int'(od_u));
    if (ovld_g) qg.push_back(int'(od_g));
  end

  // reference model state: [instance 0 main,1 unity,2 gain][section]
  int cf [3][2][5];
  int sx1 [3][2], sx2 [3][2], sy1 [3][2], sy2 [3][2];

  function automatic longint magm(int v);
    if (v < 0) return (v == -32768) ? 32767 : -v;
    return v;
  endfunction

  function automatic longint mulm(int c, int d);
    longint p = magm(c) * magm(d);
    return ((c < 0) != (d < 0)) ? -p : p;
  endfunction

  function automatic int satm(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int model(int k, int x);
    int v = x;
    for (int s = 0; s < 2; s++) begin
      longint a = mulm(cf[k][s][0], v) + mulm(cf[k][s][1], sx1[k][s]) + mulm(cf[k][s][2], sx2[k][s])
                - mulm(cf[k][s][3], sy1[k][s]) - mulm(cf[k][s][4], sy2[k][s]);
      int y = satm((a + 8192) >>> 14);
      sx2[k][s] = sx1[k][s]; sx1[k][s] = v;
      sy2[k][s] = sy1[k][s]; sy1[k][s] = y;
      v = y;
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 2; s++) begin
        sx1[k][s] = 0; sx2[k][s] = 0; sy1[k][s] = 0; sy2[k][s] = 0;
      end
    rst = 1'b0;
    qm.delete(); qu.delete(); qg.delete();
  endtask

  task automatic send(int x);
    @(negedge clk); in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_check(int k, int exp, string req);
    int act;
    if (k == 0 && qm.size() > 0) act = qm.pop_front();
    else if (k == 1 && qu.size() > 0) act = qu.pop_front();
    else if (k == 2 && qg.size() > 0) act = qg.pop_front();
    else begin check(1'b0, {req, " missing output"}, 0, exp); return; end
    check(act == exp, req, act, exp);
  endtask

  task automatic t_reset_R1();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ovld_m == 1'b0, "R1 out_valid in reset", int'(ovld_m), 0);
    check(ov_m == 1'b0, "R1 overrun in reset", int'(ov_m), 0);
    check(od_m == 16'sd0, "R1 out_data in reset", int'(od_m), 0);
    do_reset();
    repeat (2) @(negedge clk);
    check(ovld_m == 1'b0 && ov_m == 1'b0, "R1 idle after reset", int'(ovld_m) + int'(ov_m), 0);
  endtask

  task automatic t_latency_R2();
    int k;
    do_reset();
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd100;
    @(negedge clk); in_valid = 1'b0; k = 1;
    while (!ovld_m && k < 30) begin @(negedge clk); k++; end
    check(k == 12, "R2 output latency", k, 12);
    @(negedge clk);
    check(ovld_m == 1'b0, "R2 one-cycle pulse", int'(ovld_m), 0);
    void'(model(0, 100));
  endtask

  task automatic t_impulse_R3();
    int e [20];
    do_reset();
    for (int i = 0; i < 20; i++) begin
      int x = (i == 0) ? 16384 : 0;
      e[i] = model(0, x);
      send(x);
    end
    repeat (16) @(negedge clk);
    check(qm.size() == 20, "R3 impulse output count", qm.size(), 20);
    for (int i = 0; i < 20; i++) pop_check(0, e[i], "R3 impulse");
  endtask

  task automatic t_step_R7();
    int e [30];
    do_reset();
    for (int i = 0; i < 30; i++) begin
      e[i] = model(0, 12000);
      send(12000);
    end
    repeat (16) @(negedge clk);
    check(qm.size() == 30, "R7 back-to-back count", qm.size(), 30);
    check(ov_m == 1'b0, "R7 no overrun at full rate", int'(ov_m), 0);
    for (int i = 0; i < 30; i++) pop_check(0, e[i], "R3 R7 step");
  endtask

  task automatic t_round_R4();
    do_reset();
    send(3); send(-3);
    repeat (16) @(negedge clk);
    pop_check(1, 2, "R4 round 1.5");
    pop_check(1, -1, "R4 round -1.5");
  endtask

  task automatic t_sat_R5();
    do_reset();
    send(20000); send(-20000);
    repeat (16) @(negedge clk);
    pop_check(2, 32767, "R5 positive saturation");
    pop_check(2, -32767, "R5 negative saturation");
  endtask

  task automatic t_minneg_R6();
    do_reset();
    send(-32768); send(32767);
    repeat (16) @(negedge clk);
    pop_check(1, -16383, "R6 most negative operand");
    pop_check(1, 16384, "R6 max positive operand");
  endtask

  task automatic t_overrun_R8();
    int ea, ec;
    do_reset();
    ea = model(0, 9000);
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd9000;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); in_valid = 1'b1; in_data = -16'sd20000;
    @(negedge clk); in_valid = 1'b0;
    check(ov_m == 1'b1, "R9 overrun set on dropped strobe", int'(ov_m), 1);
    repeat (16) @(negedge clk);
    check(qm.size() == 1, "R8 dropped strobe gives no output", qm.size(), 1);
    pop_check(0, ea, "R8 accepted sample");
    ec = model(0, 4000);
    send(4000);
    repeat (16) @(negedge clk);
    pop_check(0, ec, "R8 state untouched by dropped strobe");
    check(ov_m == 1'b1, "R9 overrun sticky", int'(ov_m), 1);
    do_reset();
    check(ov_m == 1'b0, "R9 overrun cleared by reset", int'(ov_m), 0);
  endtask

  initial begin
    cf[0][0] = '{2048, 4096, 2048, -16384, 8192};
    cf[0][1] = '{1024, 2048, 1024, -19661, 7373};
    cf[1][0] = '{8192, 0, 0, 0, 0};
    cf[1][1] = '{16384, 0, 0, 0, 0};
    cf[2][0] = '{32767, 0, 0, 0, 0};
    cf[2][1] = '{16384, 0, 0, 0, 0};
    t_reset_R1();
    t_latency_R2();
    t_impulse_R3();
    t_step_R7();
    t_round_R4();
    t_sat_R5();
    t_minneg_R6();
    t_overrun_R8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule